// File: doc/BRIEF.md
# SCL Clock Divider

This block derives the serial clock of a two-wire bus controller from the system clock. A power-of-two prescaler produces a base tick every 2^E system clocks. Two phase counters then hold the line low for one programmed number of base ticks and release it for another. Each phase field stores its length minus one, so a field value of zero gives a phase of one tick. The resulting SCL period is 2^E × (lowPhase + 1 + highPhase + 1) system clocks.

The block drives an open-drain pad through a drive-low enable. It watches the real line level on `sclIn`. While the line is released, the high phase does not count until the line actually reads high, so a target that holds the clock low stretches the high phase. A byte engine running beside the divider receives single-cycle strobes at each falling edge, each rising edge, and the midpoint of each phase.

The three timing fields are captured together at the start of every low phase. A period therefore never mixes old and new settings. Deasserting `enable` releases the line and parks the divider. Reasserting it starts a fresh period with a low phase.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is asserted, and afterwards until enable is seen high, `sclDriveLow` and all four strobes are 0.
- R2: One clock after `enable` is sampled low, `sclDriveLow` is 0, and it stays 0 with no strobe while `enable` stays low.
- R3: In the cycle after `enable` is first sampled high, `sclFall` pulses for one cycle and `sclDriveLow` becomes 1.
- R4: With exponent E, the time from `sclFall` to the following `sclRise` is (lowPhase+1)·2^E clocks. Without stretching, the time from that `sclRise` to the next `sclFall` is (highPhase+1)·2^E clocks. No two base ticks are closer than 2^E clocks within a phase.
- R5: A phase field of 0 yields a phase of one base tick. With E=0 and both fields 0, the SCL period is 2 clocks.
- R6: During the high phase, a base tick on which `sclIn` reads 0 is not counted. With E=0, each such cycle lengthens the high phase, and delays `highMid`, by one clock.
- R7: `baseExp`, `lowPhase` and `highPhase` are captured only at the start of a low phase, in the cycle that `sclFall` pulses. A change made during a period takes effect from the next `sclFall`.
- R8: `lowMid` pulses (lowPhase/2 + 1)·2^E clocks after `sclFall`, using integer division. `highMid` pulses (highPhase/2 + 1)·2^E counted high-phase clocks after `sclRise`. A mid strobe may coincide with the phase-ending edge strobe when the field is 0.
- R9: `sclRise` pulses only in the first cycle with `sclDriveLow` 0 after a cycle with it at 1. `sclFall` pulses only in the first cycle with `sclDriveLow` 1 after a cycle with it at 0. The two never pulse together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the divider; low releases the line and parks it |
| baseExp | input | 4 | Prescaler exponent E; base tick every 2^E clocks |
| lowPhase | input | 4 | Low phase length in base ticks, minus one |
| highPhase | input | 4 | High phase length in base ticks, minus one |
| sclIn | input | 1 | Synchronised level of the SCL line |
| sclDriveLow | output | 1 | 1 pulls SCL low; 0 releases it |
| sclRise | output | 1 | One-cycle strobe when the line is released |
| sclFall | output | 1 | One-cycle strobe when the line is pulled low |
| lowMid | output | 1 | One-cycle strobe at the low phase midpoint |
| highMid | output | 1 | One-cycle strobe at the high phase midpoint |

## Verification
The assertions assume that `sclIn` is already synchronised to `clk`. They also assume it reads high in the cycle after release unless a target is stretching the clock. The bench models the open-drain line as the inverse of `sclDriveLow`, combined with a hold that it raises only on the clock edges that follow a rise strobe, so stretching only ever lengthens a high phase. The bench changes the timing fields only in the one or two cycles after a fall strobe. It also makes sure that the period in progress is at least two clocks long at that moment, so a capture edge is never raced.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } sclPhase_e;

  // strobes from the sequencer to the counting datapath
  typedef struct packed {
    logic restart;  // restart the prescaler on this edge
    logic load;     // capture the timing fields
    logic clear;    // zero the phase counter
    logic advance;  // count one base tick in the phase
    logic inHigh;   // phase counter compares against the high field
  } divCtl_t;

endpackage

// File: rtl/scl_div_datapath.sv
module scl_div_datapath
  import scl_div_pkg::*;
#(
  parameter int EXP_W   = 4,
  parameter int PHASE_W = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           enable,
  input  logic [EXP_W-1:0]               baseExp,
  input  logic [PHASE_W-1:0]             lowPhase,
  input  logic [PHASE_W-1:0]             highPhase,
  input  divCtl_t                        ctl,
  output logic                           tick,
  output logic                           phaseLast,
  output logic                           phaseMid,
  output logic [EXP_W+2*PHASE_W-1:0]     latchedCfg
);

  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   preMask;
  logic [EXP_W-1:0]   expLat;
  logic [PHASE_W-1:0] lowLat;
  logic [PHASE_W-1:0] highLat;
  logic [PHASE_W-1:0] phaseCnt;
  logic [PHASE_W-1:0] curLat;

  // mask of the prescaler bits that must be zero for a base tick
  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign preMask[g] = (expLat > EXP_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN)            preCnt <= '0;
    else if (!enable)     preCnt <= '0;
    else if (ctl.restart) preCnt <= PRE_W'(1);
    else                  preCnt <= preCnt + PRE_W'(1);
  end

  assign tick = enable && ((preCnt & preMask) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expLat  <= '0;
      lowLat  <= '0;
      highLat <= '0;
    end else if (ctl.load) begin
      expLat  <= baseExp;
      lowLat  <= lowPhase;
      highLat <= highPhase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            phaseCnt <= '0;
    else if (ctl.clear)   phaseCnt <= '0;
    else if (ctl.advance) phaseCnt <= phaseCnt + PHASE_W'(1);
  end

  assign curLat     = ctl.inHigh ? highLat : lowLat;
  assign phaseLast  = (phaseCnt == curLat);
  assign phaseMid   = (phaseCnt == (curLat >> 1));
  assign latchedCfg = {expLat, highLat, lowLat};

  // R4: with a prescale above one, a base tick is never followed by another
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (tick && expLat != '0 && !ctl.load) |=> !tick);

endmodule

// File: rtl/scl_div_ctrl.sv
module scl_div_ctrl
  import scl_div_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    sclIn,
  input  logic    tick,
  input  logic    phaseLast,
  input  logic    phaseMid,
  output divCtl_t ctl,
  output logic    sclDriveLow,
  output logic    sclRise,
  output logic    sclFall,
  output logic    lowMid,
  output logic    highMid
);

  sclPhase_e phase, nextPh;
  logic riseN, fallN, lowMidN, highMidN;

  always_comb begin
    nextPh     = phase;
    ctl        = '0;
    ctl.inHigh = (phase == PH_HIGH);
    riseN      = 1'b0;
    fallN      = 1'b0;
    lowMidN    = 1'b0;
    highMidN   = 1'b0;
    if (!enable) begin
      nextPh = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: begin
          nextPh      = PH_LOW;
          ctl.load    = 1'b1;
          ctl.clear   = 1'b1;
          ctl.restart = 1'b1;
          fallN       = 1'b1;
        end
        PH_LOW: begin
          if (tick) begin
            lowMidN = phaseMid;
            if (phaseLast) begin
              nextPh    = PH_HIGH;
              ctl.clear = 1'b1;
              riseN     = 1'b1;
            end else begin
              ctl.advance = 1'b1;
            end
          end
        end
        PH_HIGH: begin
          // a tick only counts once the line really reads high
          if (tick && sclIn) begin
            highMidN = phaseMid;
            if (phaseLast) begin
              nextPh      = PH_LOW;
              ctl.load    = 1'b1;
              ctl.clear   = 1'b1;
              ctl.restart = 1'b1;
              fallN       = 1'b1;
            end else begin
              ctl.advance = 1'b1;
            end
          end
        end
        default: nextPh = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      sclDriveLow <= 1'b0;
      sclRise     <= 1'b0;
      sclFall     <= 1'b0;
      lowMid      <= 1'b0;
      highMid     <= 1'b0;
    end else begin
      phase       <= nextPh;
      sclDriveLow <= (nextPh == PH_LOW);
      sclRise     <= riseN;
      sclFall     <= fallN;
      lowMid      <= lowMidN;
      highMid     <= highMidN;
    end
  end

  // R2: a cycle with enable low leaves the line released and quiet
  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> (!sclDriveLow && !sclRise && !sclFall && !lowMid && !highMid));

  // R3: turning the divider on starts with a falling edge
  a_r3_fall_on_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |=> sclFall);

  // R6: a held-low line freezes the high phase
  a_r6_stretch_hold: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && !sclIn) |=> (!sclFall && !highMid));

  // R9: edge strobes agree with the drive output
  a_r9_rise_edge: assert property (@(posedge clk) disable iff (!rstN)
    sclRise |-> (!sclDriveLow && $past(sclDriveLow) && !sclFall));

  a_r9_fall_edge: assert property (@(posedge clk) disable iff (!rstN)
    sclFall |-> (sclDriveLow && !$past(sclDriveLow)));

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_div_pkg::*;
#(
  parameter int EXP_W   = 4,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [EXP_W-1:0]   baseExp,
  input  logic [PHASE_W-1:0] lowPhase,
  input  logic [PHASE_W-1:0] highPhase,
  input  logic               sclIn,
  output logic               sclDriveLow,
  output logic               sclRise,
  output logic               sclFall,
  output logic               lowMid,
  output logic               highMid
);

  localparam int CFG_W = EXP_W + 2 * PHASE_W;

  divCtl_t          ctl;
  logic             tick;
  logic             phaseLast;
  logic             phaseMid;
  logic [CFG_W-1:0] latchedCfg;

  scl_div_datapath #(
    .EXP_W   (EXP_W),
    .PHASE_W (PHASE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .baseExp    (baseExp),
    .lowPhase   (lowPhase),
    .highPhase  (highPhase),
    .ctl        (ctl),
    .tick       (tick),
    .phaseLast  (phaseLast),
    .phaseMid   (phaseMid),
    .latchedCfg (latchedCfg)
  );

  scl_div_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .sclIn       (sclIn),
    .tick        (tick),
    .phaseLast   (phaseLast),
    .phaseMid    (phaseMid),
    .ctl         (ctl),
    .sclDriveLow (sclDriveLow),
    .sclRise     (sclRise),
    .sclFall     (sclFall),
    .lowMid      (lowMid),
    .highMid     (highMid)
  );

  // R7: captured settings move only together with a falling-edge strobe
  a_r7_load_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(latchedCfg) |-> sclFall);

endmodule

// File: tb/sim_scl_clock_gen.sv
`timescale 1ns/1ps
module sim_scl_clock_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] baseExp = '0;
  logic [3:0] lowPhase = '0;
  logic [3:0] highPhase = '0;
  logic       sclIn;
  logic       sclDriveLow, sclRise, sclFall, lowMid, highMid;

  always #10 clk = ~clk;  // 50 MHz

  scl_clock_gen u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .baseExp(baseExp),
    .lowPhase(lowPhase), .highPhase(highPhase), .sclIn(sclIn),
    .sclDriveLow(sclDriveLow), .sclRise(sclRise), .sclFall(sclFall),
    .lowMid(lowMid), .highMid(highMid)
  );

  int nVec = 0;
  int nBad = 0;
  int cyc = 0;
  int refCyc = 0;
  int stretchK = 0;
  int holdLeft = 0;
  logic hold = 1'b0;
  logic prevDrive = 1'b0;
  int curE, curLo, curHi;

  // scoreboard: event kind 0 lowMid, 1 rise, 2 highMid, 3 fall
  int    kindQ[$];
  int    offQ[$];
  string tagQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  // open-drain line with an optional target holding it after a rise
  assign sclIn = !sclDriveLow && !hold;

  always @(negedge clk) begin
    if (sclRise && stretchK > 0) holdLeft = stretchK;
    else if (holdLeft > 0)       holdLeft = holdLeft - 1;
    hold = (holdLeft > 0);
  end

  task automatic checkEvt(int kind);
    int k, o;
    string t;
    if (kindQ.size() == 0) return;
    k = kindQ.pop_front();
    o = offQ.pop_front();
    t = tagQ.pop_front();
    nVec++;
    if (k != kind || (cyc - refCyc) != o) begin
      nBad++;
      $display("FAIL %s: event %0d at offset %0d, expected event %0d at offset %0d",
               t, kind, cyc - refCyc, k, o);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (sclRise) begin  // R9
        nVec++;
        if (sclDriveLow !== 1'b0 || prevDrive !== 1'b1 || sclFall) begin
          nBad++;
          $display("FAIL R9: rise with drive %b prev %b fall %b, expected 0 1 0",
                   sclDriveLow, prevDrive, sclFall);
        end
      end
      if (sclFall) begin  // R9
        nVec++;
        if (sclDriveLow !== 1'b1 || prevDrive !== 1'b0) begin
          nBad++;
          $display("FAIL R9: fall with drive %b prev %b, expected 1 0",
                   sclDriveLow, prevDrive);
        end
      end
      if (highMid) checkEvt(2);
      if (sclFall) begin
        checkEvt(3);
        refCyc = cyc;
      end
      if (lowMid)  checkEvt(0);
      if (sclRise) checkEvt(1);
    end
    prevDrive = sclDriveLow;
  end

  task automatic pushEvt(int k, int o, string t);
    kindQ.push_back(k);
    offQ.push_back(o);
    tagQ.push_back(t);
  endtask

  task automatic pushPeriod(int e, int lo, int hi, int k, string t);
    int tk;
    tk = 1 << e;
    pushEvt(0, ((lo >> 1) + 1) * tk, "R8");
    pushEvt(1, (lo + 1) * tk, t);
    pushEvt(2, (lo + 1) * tk + ((hi >> 1) + 1) * tk + k, "R8");
    pushEvt(3, (lo + 1) * tk + (hi + 1) * tk + k, t);
  endtask

  task automatic drain();
    while (kindQ.size() > 0) @(negedge clk);
  endtask

  task automatic startRun(int e, int lo, int hi, int n, string t);
    @(negedge clk);
    baseExp   = 4'(e);
    lowPhase  = 4'(lo);
    highPhase = 4'(hi);
    stretchK  = 0;
    refCyc    = cyc;
    enable    = 1'b1;
    pushEvt(3, 1, "R3");  // R3: first fall one cycle after enable
    for (int i = 0; i < n; i++) pushPeriod(e, lo, hi, 0, t);
    curE = e; curLo = lo; curHi = hi;
    drain();
  endtask

  // R7: the period in progress keeps the old fields
  task automatic retune(int e, int lo, int hi, int k, int n, string t);
    pushPeriod(curE, curLo, curHi, k, "R7");
    for (int i = 0; i < n; i++) pushPeriod(e, lo, hi, k, t);
    stretchK  = k;
    baseExp   = 4'(e);
    lowPhase  = 4'(lo);
    highPhase = 4'(hi);
    curE = e; curLo = lo; curHi = hi;
    drain();
  endtask

  task automatic offCheck();
    int bad;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    nVec++;  // R2 first cycle
    if (sclDriveLow !== 1'b0) begin
      nBad++;
      $display("FAIL R2: drive %b one cycle after disable, expected 0", sclDriveLow);
    end
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sclDriveLow || sclRise || sclFall || lowMid || highMid) bad++;
    end
    nVec++;  // R2 stays quiet
    if (bad != 0) begin
      nBad++;
      $display("FAIL R2: %0d active cycles while disabled, expected 0", bad);
    end
  endtask

  task automatic resetCheck(string t);
    nVec++;
    if ({sclDriveLow, sclRise, sclFall, lowMid, highMid} !== 5'b0) begin
      nBad++;
      $display("FAIL %s: outputs %b, expected 00000", t,
               {sclDriveLow, sclRise, sclFall, lowMid, highMid});
    end
  endtask

  task automatic runAll();
    repeat (3) @(negedge clk);
    resetCheck("R1");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    resetCheck("R1");
    startRun(0, 0, 0, 3, "R5");      // minimum period of 2 clocks
    retune(1, 3, 2, 0, 3, "R4");
    retune(3, 5, 7, 0, 2, "R4");
    retune(0, 15, 15, 0, 2, "R4");
    retune(0, 2, 3, 4, 3, "R6");     // stretched high phase
    retune(12, 0, 1, 0, 2, "R4");
    retune(1, 1, 1, 0, 2, "R7");
    offCheck();
    startRun(2, 4, 0, 2, "R3");
    retune(0, 1, 0, 0, 2, "R5");
    offCheck();
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (195000) @(posedge clk);
        nBad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule